// File: doc/BRIEF.md
# Bus Grant Controller

This block decides when the processor-side bus interface hands the external bus over to another master. It uses an active-low handshake of three signals: an incoming request, an outgoing grant, and an incoming acknowledge that the new master holds for as long as it owns the bus. The processor always has the lowest priority. A pending external request therefore wins at the next point where giving up the bus is safe. That point is when no operand transfer is still in flight and no locked read-modify-write sequence is open.

The request and acknowledge inputs are brought into the clock domain through two-stage synchronisers. Once acknowledge is seen, grant is released after a fixed delay. If a request is still pending while the current master holds the bus, grant is issued again after a second delay, so that external priority logic can choose the next master early. The block also tells the processor when it may start bus cycles. It supplies an output enable for the address, function-code, size and direction outputs, and holds the values of those outputs in a register. The register freezes while the processor is halted, stopped on a double fault, or off the bus, so the outputs come back with their previous values if the processor is still halted when the bus returns.

Top module: `bus_grant_ctrl`

## Requirements
- R1: In reset and just after it, `grant_n` is 1, `drive_en` and `cpu_go` are 1, `bus_addr`, `bus_fc` and `bus_size` are 0, and `bus_rw` is 1 (read).
- R2: `bus_req_n` and `grant_ack_n` each pass through two flip-flops. With the boundary open and the bus idle, `grant_n` goes to 0 on the third rising edge after `bus_req_n` falls, and not earlier.
- R3: While `xfer_busy` is 1, no grant is issued. With the request already synchronised, `grant_n` falls on the first rising edge after `xfer_busy` drops.
- R4: While `rmw_lock` is 1, no grant is issued. With the request already synchronised, `grant_n` falls on the first rising edge after `rmw_lock` drops.
- R5: `halt` and `dbl_fault` have no effect on when a request is granted. The latency of R2 is the same for all four combinations of the two signals.
- R6: Once the synchronised acknowledge becomes active, `grant_n` stays 0 for NEG_DLY more rising edges and then returns to 1. With the defaults this is on the fifth rising edge after `grant_ack_n` falls.
- R7: With acknowledge held and no request pending, `grant_n` stays 1. If a request is pending, `grant_n` falls again REGRANT_DLY edges after reaching the owned state (eighth edge after `grant_ack_n` falls, defaults), and it stays 0 while the old master releases and until a new acknowledge arrives.
- R8: `drive_en` is 0 while a grant is outstanding and while the synchronised acknowledge is active.
- R9: `cpu_go` is 0 while a grant is outstanding or acknowledge is active. After `grant_ack_n` rises with no grant outstanding, `cpu_go` returns to 1 on the third rising edge.
- R10: The bus output register loads `cpu_*` one cycle later only while `cpu_go` is 1 and both `halt` and `dbl_fault` are 0. Otherwise it holds its value, so the outputs come back unchanged when the bus returns during a halt.
- R11: If the request is withdrawn while grant is outstanding and before any acknowledge, `grant_n` returns to 1 on the third rising edge after `bus_req_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_n | input | 1 | External bus request, active low, asynchronous |
| grant_ack_n | input | 1 | External grant acknowledge, active low, asynchronous |
| xfer_busy | input | 1 | Processor is inside an operand transfer |
| rmw_lock | input | 1 | Indivisible read-modify-write sequence in progress |
| halt | input | 1 | Processor halt status |
| dbl_fault | input | 1 | Processor stopped on a double bus fault |
| cpu_addr | input | 24 | Address from the bus cycle logic |
| cpu_fc | input | 3 | Function code from the bus cycle logic |
| cpu_size | input | 2 | Transfer size from the bus cycle logic |
| cpu_rw | input | 1 | Direction from the bus cycle logic, 1 = read |
| grant_n | output | 1 | Bus grant, active low |
| drive_en | output | 1 | Output enable for address and control pads |
| cpu_go | output | 1 | Processor may start bus cycles |
| bus_addr | output | 24 | Held address toward the pads |
| bus_fc | output | 3 | Held function code toward the pads |
| bus_size | output | 2 | Held size toward the pads |
| bus_rw | output | 1 | Held direction toward the pads |

## Verification
The grant path is tried with a request arriving while a transfer is open, while a locked sequence is open, and with the boundary already clear. The last case is swept over all four halt and double-fault combinations. Comparing the latencies shows whether a gating signal that should block actually blocks, and whether status signals that should not block leak into arbitration. Tenures are run with the request dropped together with acknowledge and with the request held through acknowledge, which separates a single release from a re-grant. A withdrawn request checks the abort path. Output values are compared across tenures with halt held, with halt clear, and with a double fault, which shows whether the register freezes or follows its inputs.

// File: rtl/bga_pkg.sv
package bga_pkg;

    localparam int BGA_ADDR_W = 24;
    localparam int BGA_FC_W   = 3;
    localparam int BGA_SIZE_W = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT,
        S_NEG_WAIT,
        S_OWNED,
        S_RE_WAIT,
        S_PREGRANT
    } arb_state_e;

    typedef struct packed {
        logic [BGA_ADDR_W-1:0] addr;
        logic [BGA_FC_W-1:0]   fc;
        logic [BGA_SIZE_W-1:0] size;
        logic                  rw;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_CTL_RST = '{addr: '0, fc: '0, size: '0, rw: 1'b1};

    function automatic logic grant_out(arb_state_e s);
        return (s == S_GRANT) || (s == S_NEG_WAIT) || (s == S_PREGRANT);
    endfunction

endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[i] <= RST_VAL;
            else if (i == 0)
                stg[i] <= d;
            else
                stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bga_fsm.sv
module bga_fsm
    import bga_pkg::*;
#(
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_act,
    input  logic ack_act,
    input  logic xfer_busy,
    input  logic rmw_lock,
    output logic grant_act,
    output logic cpu_go
);
    localparam int MAX_DLY = (NEG_DLY > REGRANT_DLY) ? NEG_DLY : REGRANT_DLY;
    localparam int CW      = $clog2(MAX_DLY + 1);

    arb_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                S_IDLE:
                    if (req_act && !ack_act && !xfer_busy && !rmw_lock)
                        state <= S_GRANT;
                S_GRANT:
                    if (ack_act) begin
                        state <= S_NEG_WAIT;
                        cnt   <= CW'(NEG_DLY - 1);
                    end else if (!req_act) begin
                        state <= S_IDLE;
                    end
                S_NEG_WAIT:
                    if (cnt == '0) state <= S_OWNED;
                    else           cnt   <= cnt - 1'b1;
                S_OWNED:
                    if (!ack_act) begin
                        state <= S_IDLE;
                    end else if (req_act) begin
                        state <= S_RE_WAIT;
                        cnt   <= CW'(REGRANT_DLY - 1);
                    end
                S_RE_WAIT:
                    if (!ack_act)        state <= S_IDLE;
                    else if (!req_act)   state <= S_OWNED;
                    else if (cnt == '0)  state <= S_PREGRANT;
                    else                 cnt   <= cnt - 1'b1;
                S_PREGRANT:
                    if (!ack_act) state <= S_GRANT;
                default:
                    state <= S_IDLE;
            endcase
        end
    end

    assign grant_act = grant_out(state);
    assign cpu_go    = (state == S_IDLE) && !ack_act;

    // R3 / R4: a fresh grant out of idle only follows a clear boundary
    a_r3_r4_grant_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (state == S_GRANT && $past(state) == S_IDLE) |-> $past(!xfer_busy && !rmw_lock));

    // R11: abort to idle only when request gone and no acknowledge seen
    a_r11_abort_needs_release: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && $past(state) == S_GRANT) |-> $past(!req_act && !ack_act));

    // R7: re-grant countdown only starts with a request pending
    a_r7_regrant_needs_req: assert property (@(posedge clk) disable iff (rst)
        (state == S_RE_WAIT && $past(state) == S_OWNED) |-> $past(req_act && ack_act));
endmodule

// File: rtl/bga_hold.sv
module bga_hold
    import bga_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  bus_ctl_t d,
    output bus_ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= BUS_CTL_RST;
        else if (load) q <= d;
    end

    // R10: held values do not move when loading is blocked
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
    import bga_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req_n,
    input  logic                  grant_ack_n,
    input  logic                  xfer_busy,
    input  logic                  rmw_lock,
    input  logic                  halt,
    input  logic                  dbl_fault,
    input  logic [BGA_ADDR_W-1:0] cpu_addr,
    input  logic [BGA_FC_W-1:0]   cpu_fc,
    input  logic [BGA_SIZE_W-1:0] cpu_size,
    input  logic                  cpu_rw,
    output logic                  grant_n,
    output logic                  drive_en,
    output logic                  cpu_go,
    output logic [BGA_ADDR_W-1:0] bus_addr,
    output logic [BGA_FC_W-1:0]   bus_fc,
    output logic [BGA_SIZE_W-1:0] bus_size,
    output logic                  bus_rw
);
    logic [1:0] raw_n, sync_n;
    logic       req_act, ack_act, grant_act, go;
    bus_ctl_t   cpu_ctl, held;

    assign raw_n = {grant_ack_n, bus_req_n};

    bga_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_n),
        .q   (sync_n)
    );

    assign req_act = !sync_n[0];
    assign ack_act = !sync_n[1];

    bga_fsm #(.NEG_DLY(NEG_DLY), .REGRANT_DLY(REGRANT_DLY)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_act   (req_act),
        .ack_act   (ack_act),
        .xfer_busy (xfer_busy),
        .rmw_lock  (rmw_lock),
        .grant_act (grant_act),
        .cpu_go    (go)
    );

    assign cpu_ctl = '{addr: cpu_addr, fc: cpu_fc, size: cpu_size, rw: cpu_rw};

    bga_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (go && !halt && !dbl_fault),
        .d    (cpu_ctl),
        .q    (held)
    );

    assign grant_n  = !grant_act;
    assign cpu_go   = go;
    assign drive_en = go;
    assign bus_addr = held.addr;
    assign bus_fc   = held.fc;
    assign bus_size = held.size;
    assign bus_rw   = held.rw;

    // R1: coming out of reset the processor owns the bus with grant off
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grant_n && cpu_go));

    // R8: pads released whenever an external master acknowledges
    a_r8_hiz_on_ack: assert property (@(posedge clk) disable iff (rst)
        ack_act |-> !drive_en);

    // R9: processor never starts cycles with a grant outstanding
    a_r9_no_go_granted: assert property (@(posedge clk) disable iff (rst)
        !grant_n |-> !cpu_go);
endmodule

// File: tb/test_bus_grant_ctrl.sv
module test_bus_grant_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req_n = 1'b1, grant_ack_n = 1'b1;
    logic        xfer_busy = 1'b0, rmw_lock = 1'b0, halt = 1'b0, dbl_fault = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [2:0]  cpu_fc = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_rw = 1'b1;
    logic        grant_n, drive_en, cpu_go;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic [1:0]  bus_size;
    logic        bus_rw;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    bus_grant_ctrl i_bus_grant_ctrl (
        .clk(clk), .rst(rst), .bus_req_n(bus_req_n), .grant_ack_n(grant_ack_n),
        .xfer_busy(xfer_busy), .rmw_lock(rmw_lock), .halt(halt), .dbl_fault(dbl_fault),
        .cpu_addr(cpu_addr), .cpu_fc(cpu_fc), .cpu_size(cpu_size), .cpu_rw(cpu_rw),
        .grant_n(grant_n), .drive_en(drive_en), .cpu_go(cpu_go),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_size(bus_size), .bus_rw(bus_rw)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pack(input logic [23:0] a, input logic [2:0] f,
                                         input logic [1:0] s, input logic r);
        return {2'b00, a, f, s, r};
    endfunction

    function automatic logic [31:0] bus_now();
        return pack(bus_addr, bus_fc, bus_size, bus_rw);
    endfunction

    task automatic set_cpu(input logic [23:0] a, input logic [2:0] f,
                           input logic [1:0] s, input logic r);
        cpu_addr = a; cpu_fc = f; cpu_size = s; cpu_rw = r;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // one tenure: request, grant, acknowledge with request dropped, release
    task automatic tenure_start();
        bus_req_n = 1'b0;
        edges(3);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        edges(5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 grant_n", grant_n, 1);
        check("R1 drive_en", drive_en, 1);
        check("R1 cpu_go", cpu_go, 1);
        check("R1 bus", bus_now(), pack(24'h0, 3'h0, 2'h0, 1'b1));

        // R3 transfer in flight blocks grant
        xfer_busy = 1'b1; bus_req_n = 1'b0;
        edges(6);
        check("R3 held during transfer", grant_n, 1);
        xfer_busy = 1'b0;
        edges(1);
        check("R3 grant after boundary", grant_n, 0);
        // R11 withdrawn request
        bus_req_n = 1'b1;
        edges(2);
        check("R11 grant still out", grant_n, 0);
        edges(1);
        check("R11 grant withdrawn", grant_n, 1);
        edges(3);

        // R4 locked sequence blocks grant
        rmw_lock = 1'b1; bus_req_n = 1'b0;
        edges(6);
        check("R4 held during lock", grant_n, 1);
        rmw_lock = 1'b0;
        edges(1);
        check("R4 grant after unlock", grant_n, 0);
        bus_req_n = 1'b1;
        edges(5);

        // R2 / R5 latency sweep over halt and double-fault
        for (int c = 0; c < 4; c++) begin
            halt = c[0]; dbl_fault = c[1];
            bus_req_n = 1'b0;
            edges(2);
            check("R2 R5 no early grant", grant_n, 1);
            edges(1);
            check("R2 R5 grant on third edge", grant_n, 0);
            check("R8 released at grant", drive_en, 0);
            check("R9 no go at grant", cpu_go, 0);
            bus_req_n = 1'b1;
            edges(5);
        end
        halt = 1'b0; dbl_fault = 1'b0;
        edges(2);

        // R6 / R7 / R8 / R9 single tenure, request dropped with acknowledge
        bus_req_n = 1'b0;
        edges(3);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        edges(4);
        check("R6 grant held", grant_n, 0);
        edges(1);
        check("R6 grant negated", grant_n, 1);
        check("R8 released in tenure", drive_en, 0);
        edges(6);
        check("R7 no regrant without request", grant_n, 1);
        grant_ack_n = 1'b1;
        edges(2);
        check("R9 still parked", cpu_go, 0);
        edges(1);
        check("R9 resumes", cpu_go, 1);
        check("R8 drives again", drive_en, 1);
        edges(2);

        // R7 re-grant with request held through acknowledge
        bus_req_n = 1'b0;
        edges(3);
        grant_ack_n = 1'b0;
        edges(5);
        check("R7 negated after ack", grant_n, 1);
        edges(2);
        check("R7 not yet regranted", grant_n, 1);
        edges(1);
        check("R7 regranted", grant_n, 0);
        grant_ack_n = 1'b1;
        edges(3);
        check("R7 grant kept for next master", grant_n, 0);
        check("R9 no go while granted", cpu_go, 0);
        grant_ack_n = 1'b0; bus_req_n = 1'b1;
        edges(5);
        check("R6 second master negate", grant_n, 1);
        grant_ack_n = 1'b1;
        edges(3);
        check("R9 resumes after second", cpu_go, 1);
        edges(2);

        // R10 save and restore across tenures
        set_cpu(24'h123456, 3'h5, 2'h2, 1'b0);
        edges(1);
        check("R10 follows when running", bus_now(), pack(24'h123456, 3'h5, 2'h2, 1'b0));
        halt = 1'b1;
        set_cpu(24'hABCDEF, 3'h2, 2'h1, 1'b1);
        edges(2);
        check("R10 frozen in halt", bus_now(), pack(24'h123456, 3'h5, 2'h2, 1'b0));
        tenure_start();
        check("R8 hi-z in halt tenure", drive_en, 0);
        grant_ack_n = 1'b1;
        edges(3);
        check("R10 restored drive", drive_en, 1);
        check("R10 restored value", bus_now(), pack(24'h123456, 3'h5, 2'h2, 1'b0));
        halt = 1'b0;
        edges(1);
        check("R10 follows after halt", bus_now(), pack(24'hABCDEF, 3'h2, 2'h1, 1'b1));
        tenure_start();
        set_cpu(24'h00F00D, 3'h7, 2'h3, 1'b0);
        edges(2);
        check("R10 frozen off bus", bus_now(), pack(24'hABCDEF, 3'h2, 2'h1, 1'b1));
        grant_ack_n = 1'b1;
        edges(3);
        check("R10 value on return", bus_now(), pack(24'hABCDEF, 3'h2, 2'h1, 1'b1));
        edges(1);
        check("R10 loads after return", bus_now(), pack(24'h00F00D, 3'h7, 2'h3, 1'b0));
        dbl_fault = 1'b1;
        set_cpu(24'h0000AA, 3'h1, 2'h0, 1'b1);
        edges(2);
        check("R10 frozen on double fault", bus_now(), pack(24'h00F00D, 3'h7, 2'h3, 1'b0));
        dbl_fault = 1'b0;
        edges(1);
        check("R10 loads after fault clear", bus_now(), pack(24'h0000AA, 3'h1, 2'h0, 1'b1));

        finish_run();
    end
endmodule